// File: doc/BRIEF.md
# Add-Compare-Select State Metric Unit

This unit holds and updates the four path metrics of a Viterbi decoder. The code it decodes is rate 1/2, constraint length 3, feed-forward, with generator taps 111 and 101. For each accepted symbol the unit takes four branch metrics from an upstream branch-metric stage, one per possible two-bit code word. For every next state it forms the two candidate metrics, one through each predecessor, by a saturating add. It keeps the smaller candidate and records which predecessor won in a one-bit decision per state, which a separate traceback store consumes. It also reports which state currently has the lowest metric.

Metrics start asymmetrically: the all-zeros state at zero and the other three at full scale. A two-bit mode input chooses between continuous decoding and per-frame decoding. In continuous decoding, metrics run on across frame boundaries and a clear request re-initialises them. In per-frame decoding, the first symbol of every frame is evaluated against the initial metrics. The clear request is ignored in that case. When the minimum metric climbs into the upper half of the range, all metrics are renormalised so that they cannot overflow.

Top module: `acs_metric_unit`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, state 0 holds metric 0, states 1 to 3 hold 2^SMW-1, and `dec_out` and `out_valid` are 0.
- R2: State s = {newest input bit, older bit}. Input u moves state p to {u, p[1]} and emits code {u^p[1]^p[0], u^p[0]}. The branch metric for code c sits at `bm_in[c*BMW +: BMW]`. One cycle after an accepted symbol, each state's metric is the smaller of its two candidates, where a candidate is the predecessor metric plus that branch's metric.
- R3: Predecessors of state s are {s[0],0} (upper) and {s[0],1} (lower). Bit s of `dec_out` is 1 only when the lower candidate is strictly smaller, so a tie selects the upper one.
- R4: If the smallest new metric is at least 2^(SMW-1), that minimum is subtracted from every new metric before it is stored. A stored metric set therefore never has its minimum at or above 2^(SMW-1).
- R5: Candidate additions saturate at 2^SMW-1.
- R6: In continuous mode (`mode` = 0), `sym_first` has no effect and metrics carry from frame to frame.
- R7: In truncated (`mode` = 1), terminated (`mode` = 2) and reserved (`mode` = 3, treated as truncated) modes, a symbol with `sym_first` = 1 is evaluated against the R1 initial metrics rather than the stored ones.
- R8: In continuous mode, `clr` = 1 restores the R1 state on the next cycle and discards any symbol in the same cycle. In the other modes `clr` is ignored.
- R9: `out_valid` is 1 exactly in the cycle after an accepted symbol. Without a symbol or a clear, the metrics and `dec_out` hold.
- R10: `best_state` is the index of the lowest stored metric, with ties going to the lower index. In terminated mode it is forced to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | 0 continuous, 1 truncated, 2 terminated, 3 as truncated |
| clr | input | 1 | Metric re-initialise request (continuous mode only) |
| sym_valid | input | 1 | Branch metrics on `bm_in` are valid this cycle |
| sym_first | input | 1 | Symbol is the first of a frame |
| bm_in | input | 4*BMW | Branch metric per code word, code c at bits c*BMW |
| metric_out | output | 4*SMW | Stored metric per state, state s at bits s*SMW |
| dec_out | output | 4 | Decision bit per state (1 = lower predecessor) |
| best_state | output | 2 | Index of the lowest metric |
| out_valid | output | 1 | Metrics and decisions updated last cycle |

## Verification
The checker watches on every cycle that reset and continuous-mode clears leave the initial metric pattern, and that `out_valid` follows accepted symbols. It also checks that idle cycles hold the metrics and decisions, that a stored minimum never reaches half scale and drops to zero after a renormalisation, and that `best_state` always points at a minimal metric, or at 0 in terminated mode. Only the bench's scenarios can show the actual metric values, the trellis wiring, the saturation and the tie direction of the decisions. The same holds for the tie rule of `best_state` and the frame-restart and ignored-clear behaviour of the per-frame modes. The bench checks these against a forward-enumerating trellis model.

// File: rtl/acs_pkg.sv
`timescale 1ns/1ps
package acs_pkg;
  localparam int NUM_STATES = 4;
  localparam int NUM_CODES  = 4;

  typedef enum logic [1:0] {
    MODE_CONT  = 2'd0,
    MODE_TRUNC = 2'd1,
    MODE_TERM  = 2'd2,
    MODE_RSVD  = 2'd3
  } acs_mode_e;

  // predecessor of a destination state; lower=0 gives the upper branch
  function automatic logic [1:0] pred_of(input logic [1:0] dst, input logic lower);
    return {dst[0], lower};
  endfunction

  // input bit that drives a transition into the destination state
  function automatic logic in_bit_of(input logic [1:0] dst);
    return dst[1];
  endfunction

  // code word {tap 111, tap 101} for source state and input bit
  function automatic logic [1:0] code_of(input logic [1:0] src, input logic u);
    return {u ^ src[1] ^ src[0], u ^ src[0]};
  endfunction
endpackage

// File: rtl/acs_node.sv
`timescale 1ns/1ps
module acs_node
  import acs_pkg::*;
#(
  parameter int         SMW = 8,
  parameter int         BMW = 4,
  parameter logic [1:0] DST = 2'd0
) (
  input  logic [SMW-1:0]           pm_upper,
  input  logic [SMW-1:0]           pm_lower,
  input  logic [NUM_CODES*BMW-1:0] bm_flat,
  output logic [SMW-1:0]           new_metric,
  output logic                     pick_lower
);
  localparam logic [SMW-1:0] SM_MAX  = '1;
  localparam logic [1:0]     CODE_UP = code_of(pred_of(DST, 1'b0), in_bit_of(DST));
  localparam logic [1:0]     CODE_LO = code_of(pred_of(DST, 1'b1), in_bit_of(DST));
  localparam int             OFS_UP  = int'(CODE_UP) * BMW;
  localparam int             OFS_LO  = int'(CODE_LO) * BMW;

  function automatic logic [SMW-1:0] sat_add(input logic [SMW-1:0] a, input logic [BMW-1:0] b);
    logic [SMW:0] s;
    s = {1'b0, a} + {{(SMW + 1 - BMW){1'b0}}, b};
    return s[SMW] ? SM_MAX : s[SMW-1:0];
  endfunction

  logic [BMW-1:0] bm_up, bm_lo;
  logic [SMW-1:0] cand_up, cand_lo;

  assign bm_up      = bm_flat[OFS_UP +: BMW];
  assign bm_lo      = bm_flat[OFS_LO +: BMW];
  assign cand_up    = sat_add(pm_upper, bm_up);
  assign cand_lo    = sat_add(pm_lower, bm_lo);
  assign pick_lower = (cand_lo < cand_up);
  assign new_metric = pick_lower ? cand_lo : cand_up;
endmodule

// File: rtl/acs_normalize.sv
`timescale 1ns/1ps
module acs_normalize
  import acs_pkg::*;
#(
  parameter int SMW = 8
) (
  input  logic [NUM_STATES*SMW-1:0] raw_flat,
  output logic [NUM_STATES*SMW-1:0] norm_flat,
  output logic                      norm_fire
);
  localparam logic [SMW-1:0] HALF = {1'b1, {(SMW-1){1'b0}}};

  logic [SMW-1:0] floor_val;

  always_comb begin
    floor_val = raw_flat[SMW-1:0];
    for (int i = 1; i < NUM_STATES; i++) begin
      if (raw_flat[i*SMW +: SMW] < floor_val) floor_val = raw_flat[i*SMW +: SMW];
    end
  end

  assign norm_fire = (floor_val >= HALF);

  for (genvar g = 0; g < NUM_STATES; g++) begin : g_sub
    assign norm_flat[g*SMW +: SMW] = norm_fire ? (raw_flat[g*SMW +: SMW] - floor_val)
                                               : raw_flat[g*SMW +: SMW];
  end
endmodule

// File: rtl/acs_best.sv
`timescale 1ns/1ps
module acs_best
  import acs_pkg::*;
#(
  parameter int SMW = 8
) (
  input  logic [NUM_STATES*SMW-1:0] metric_flat,
  output logic [1:0]                best_idx
);
  always_comb begin
    best_idx = 2'd0;
    for (int i = 1; i < NUM_STATES; i++) begin
      if (metric_flat[i*SMW +: SMW] < metric_flat[int'(best_idx)*SMW +: SMW]) best_idx = 2'(i);
    end
  end
endmodule

// File: rtl/acs_metric_unit.sv
`timescale 1ns/1ps
module acs_metric_unit
  import acs_pkg::*;
#(
  parameter int SMW = 8,  // state metric width, at least BMW+2
  parameter int BMW = 4   // branch metric width
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [1:0]                mode,
  input  logic                      clr,
  input  logic                      sym_valid,
  input  logic                      sym_first,
  input  logic [NUM_CODES*BMW-1:0]  bm_in,
  output logic [NUM_STATES*SMW-1:0] metric_out,
  output logic [NUM_STATES-1:0]     dec_out,
  output logic [1:0]                best_state,
  output logic                      out_valid
);
  function automatic logic [SMW-1:0] init_metric(input int s);
    return (s == 0) ? '0 : '1;
  endfunction

  logic [SMW-1:0]            sm_q [NUM_STATES];
  logic [SMW-1:0]            base [NUM_STATES];
  logic [NUM_STATES*SMW-1:0] raw_flat, norm_flat;
  logic [NUM_STATES-1:0]     dec_w, dec_q;
  logic [1:0]                best_raw;
  logic                      out_valid_q;

  // named events for the checker
  logic clr_hit, frame_restart, norm_fire;

  assign clr_hit       = clr && (mode == MODE_CONT);
  assign frame_restart = sym_valid && sym_first && (mode != MODE_CONT);

  always_comb begin
    for (int s = 0; s < NUM_STATES; s++) begin
      base[s] = frame_restart ? init_metric(s) : sm_q[s];
    end
  end

  for (genvar g = 0; g < NUM_STATES; g++) begin : g_node
    localparam logic [1:0] D  = 2'(g);
    localparam int         PU = int'(pred_of(D, 1'b0));
    localparam int         PL = int'(pred_of(D, 1'b1));
    acs_node #(.SMW(SMW), .BMW(BMW), .DST(D)) u_node (
      .pm_upper   (base[PU]),
      .pm_lower   (base[PL]),
      .bm_flat    (bm_in),
      .new_metric (raw_flat[g*SMW +: SMW]),
      .pick_lower (dec_w[g])
    );
    assign metric_out[g*SMW +: SMW] = sm_q[g];
  end

  acs_normalize #(.SMW(SMW)) u_norm (
    .raw_flat  (raw_flat),
    .norm_flat (norm_flat),
    .norm_fire (norm_fire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || clr_hit) begin
      for (int s = 0; s < NUM_STATES; s++) sm_q[s] <= init_metric(s);
      dec_q       <= '0;
      out_valid_q <= 1'b0;
    end else if (sym_valid) begin
      for (int s = 0; s < NUM_STATES; s++) sm_q[s] <= norm_flat[s*SMW +: SMW];
      dec_q       <= dec_w;
      out_valid_q <= 1'b1;
    end else begin
      out_valid_q <= 1'b0;
    end
  end

  acs_best #(.SMW(SMW)) u_best (
    .metric_flat (metric_out),
    .best_idx    (best_raw)
  );

  assign best_state = (mode == MODE_TERM) ? 2'd0 : best_raw;
  assign dec_out    = dec_q;
  assign out_valid  = out_valid_q;
endmodule

// File: rtl/acs_metric_unit_chk.sv
`timescale 1ns/1ps
module acs_metric_unit_chk
  import acs_pkg::*;
#(
  parameter int SMW = 8,
  parameter int BMW = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [1:0]                mode,
  input logic                      clr,
  input logic                      sym_valid,
  input logic [NUM_STATES*SMW-1:0] metric_out,
  input logic [NUM_STATES-1:0]     dec_out,
  input logic [1:0]                best_state,
  input logic                      out_valid,
  input logic                      norm_fire
);
  localparam logic [SMW-1:0] HALF = {1'b1, {(SMW-1){1'b0}}};

  logic           was_in_reset = 1'b0;
  logic [SMW-1:0] min_metric;
  logic           init_pattern;

  always_ff @(posedge clk) was_in_reset <= !rst_n;

  always_comb begin
    min_metric = metric_out[SMW-1:0];
    for (int i = 1; i < NUM_STATES; i++)
      if (metric_out[i*SMW +: SMW] < min_metric) min_metric = metric_out[i*SMW +: SMW];
  end

  assign init_pattern = (metric_out[SMW-1:0] == '0) && (&metric_out[NUM_STATES*SMW-1:SMW]);

  AST_RESET_INIT: assert property (@(posedge clk)
    (was_in_reset && rst_n) |-> (init_pattern && !out_valid && dec_out == '0)); // R1

  AST_CLEAR_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && mode == MODE_CONT) |=> (init_pattern && !out_valid)); // R8

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && !(clr && mode == MODE_CONT)) |=> out_valid); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!sym_valid && !(clr && mode == MODE_CONT)) |=>
      (!out_valid && $stable(metric_out) && $stable(dec_out))); // R9

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (min_metric < HALF)); // R4

  AST_NORM_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (norm_fire && sym_valid && !(clr && mode == MODE_CONT)) |=> (min_metric == '0)); // R4

  AST_BEST_IS_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != MODE_TERM) |-> (metric_out[int'(best_state)*SMW +: SMW] == min_metric)); // R10

  AST_BEST_TERM: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_TERM) |-> (best_state == 2'd0)); // R10
endmodule

bind acs_metric_unit acs_metric_unit_chk #(.SMW(SMW), .BMW(BMW)) u_chk (.*);

// File: tb/acs_metric_unit_tb.sv
`timescale 1ns/1ps
module acs_metric_unit_tb;
  localparam int SMW   = 8;
  localparam int BMW   = 4;
  localparam int NS    = 4;
  localparam int MAXV  = (1 << SMW) - 1;
  localparam int HALFV = 1 << (SMW - 1);

  logic            clk = 1'b0, rst_n = 1'b0;
  logic [1:0]      mode = 2'd0;
  logic            clr = 1'b0, sym_valid = 1'b0, sym_first = 1'b0;
  logic [4*BMW-1:0] bm_in = '0;
  logic [NS*SMW-1:0] metric_out;
  logic [NS-1:0]   dec_out;
  logic [1:0]      best_state;
  logic            out_valid;

  acs_metric_unit #(.SMW(SMW), .BMW(BMW)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .clr(clr), .sym_valid(sym_valid),
    .sym_first(sym_first), .bm_in(bm_in), .metric_out(metric_out),
    .dec_out(dec_out), .best_state(best_state), .out_valid(out_valid));

  always #2.5 clk = ~clk;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;
  int exp_m[NS];
  int exp_dec = 0;
  int exp_valid = 0;
  int cur_bm[4];

  function automatic int init_of(int s);
    return (s == 0) ? 0 : MAXV;
  endfunction

  function automatic int exp_best();
    int b = 0;
    if (mode == 2'd2) return 0;
    for (int s = 1; s < NS; s++) if (exp_m[s] < exp_m[b]) b = s;
    return b;
  endfunction

  // forward trellis walk: every (source, input) pair, sources ascending
  task automatic model_step();
    int base[NS]; int nxt_m[NS]; bit have[NS]; int d = 0; int mn;
    if (!rst_n || (clr && mode == 2'd0)) begin
      for (int s = 0; s < NS; s++) exp_m[s] = init_of(s);
      exp_dec = 0; exp_valid = 0;
    end else if (sym_valid) begin
      for (int s = 0; s < NS; s++) begin
        base[s] = (sym_first && mode != 2'd0) ? init_of(s) : exp_m[s];
        have[s] = 0; nxt_m[s] = 0;
      end
      for (int p = 0; p < NS; p++) begin
        for (int u = 0; u < 2; u++) begin
          int dst = (u << 1) | (p >> 1);
          int c0 = u ^ ((p >> 1) & 1) ^ (p & 1);
          int c1 = u ^ (p & 1);
          int cand = base[p] + cur_bm[c0 * 2 + c1];
          if (cand > MAXV) cand = MAXV;
          if (!have[dst]) begin
            nxt_m[dst] = cand; have[dst] = 1;
          end else if (cand < nxt_m[dst]) begin
            nxt_m[dst] = cand; d = d | (1 << dst);
          end
        end
      end
      mn = nxt_m[0];
      for (int s = 1; s < NS; s++) if (nxt_m[s] < mn) mn = nxt_m[s];
      for (int s = 0; s < NS; s++) exp_m[s] = (mn >= HALFV) ? nxt_m[s] - mn : nxt_m[s];
      exp_dec = d; exp_valid = 1;
    end else begin
      exp_valid = 0;
    end
  endtask

  task automatic chk(string req, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_outs(string req);
    for (int s = 0; s < NS; s++) chk(req, $sformatf("metric[%0d]", s), int'(metric_out[s*SMW +: SMW]), exp_m[s]);
    chk(req, "dec_out", int'(dec_out), exp_dec);
    chk(req, "out_valid", int'(out_valid), exp_valid);
    chk(req, "best_state", int'(best_state), exp_best());
  endtask

  task automatic set_bm(int a, int b, int c, int d);
    cur_bm[0] = a; cur_bm[1] = b; cur_bm[2] = c; cur_bm[3] = d;
    for (int i = 0; i < 4; i++) bm_in[i*BMW +: BMW] = BMW'(cur_bm[i]);
  endtask

  task automatic cyc(bit v, bit f, bit c, string req);
    sym_valid = v; sym_first = f; clr = c;
    @(posedge clk);
    model_step();
    @(negedge clk);
    check_outs(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned seed_init;
    seed_init = $urandom(32'd2024);
    set_bm(0, 0, 0, 0);
    @(negedge clk);
    // R1: reset state and first cycle after release
    repeat (3) cyc(0, 0, 0, "R1");
    rst_n = 1'b1;
    cyc(0, 0, 0, "R1");

    // R5: saturation from full-scale predecessors
    mode = 2'd0;
    set_bm(15, 15, 15, 15);
    cyc(1, 0, 0, "R5");
    // R4: steady growth until renormalisation
    repeat (20) cyc(1, 0, 0, "R4");

    // R9: idle holds
    repeat (3) cyc(0, 0, 0, "R9");

    // R8: continuous clear, also beating a symbol
    cyc(0, 0, 1, "R8");
    set_bm(3, 1, 2, 0);
    cyc(1, 0, 0, "R2");
    cyc(1, 0, 1, "R8");

    // R3: ties select upper, then lower wins strictly
    set_bm(0, 0, 0, 0);
    repeat (4) cyc(1, 0, 0, "R3");
    set_bm(5, 7, 0, 2);
    cyc(1, 0, 0, "R3");
    set_bm(1, 6, 9, 4);
    cyc(1, 0, 0, "R3");

    // R6: first flag ignored in continuous mode
    set_bm(2, 9, 4, 11);
    repeat (3) cyc(1, 1, 0, "R6");

    // R7: frame restart in truncated and terminated modes
    mode = 2'd1;
    set_bm(6, 2, 8, 1);
    repeat (3) cyc(1, 0, 0, "R7");
    cyc(1, 1, 0, "R7");
    mode = 2'd2;
    repeat (2) cyc(1, 0, 0, "R10");
    cyc(1, 1, 0, "R7");
    mode = 2'd3;
    cyc(1, 1, 0, "R7");

    // R8: clear ignored outside continuous mode
    mode = 2'd1;
    cyc(0, 0, 1, "R8");
    cyc(1, 0, 1, "R8");

    // R10: best-state tie toward lower index, continuous
    mode = 2'd0;
    cyc(0, 0, 1, "R10");
    set_bm(0, 0, 0, 0);
    repeat (4) cyc(1, 0, 0, "R10");
    set_bm(4, 0, 0, 4);
    cyc(1, 0, 0, "R10");

    // R2: constrained random traffic
    for (int i = 0; i < 600; i++) begin
      if ($urandom_range(0, 19) == 0) mode = 2'($urandom_range(0, 3));
      set_bm($urandom_range(0, 15), $urandom_range(0, 15), $urandom_range(0, 15), $urandom_range(0, 15));
      cyc($urandom_range(0, 3) != 0, $urandom_range(0, 9) == 0, $urandom_range(0, 29) == 0, "R2");
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule